// File: doc/BRIEF.md
# Snapshot-Read Match Timer

This block is a memory-mapped system timer. A 64-bit up-counter advances once per prescaler period, where the period is a software-set number of input clocks. Six 32-bit compare channels watch the low counter word. Each channel has a sticky status bit and an interrupt enable. Software reads the 64-bit count safely by first writing a capture command and then reading two frozen snapshot words. Because of this, a carry between the words can never appear torn. One compare channel can also drive a single-cycle watchdog reset pulse.

The timer is used as a system clock source and as a one-shot event generator. Software programs a compare value some ticks ahead of the captured count. It then waits for the channel interrupt and acknowledges it by writing a one to the status bit. Both counter words are writable, so a saved count can be restored.

Top module: `latched_match_timer`

## Requirements
- R1: After reset the counter words, divider, status, interrupt enables, watchdog enable and both snapshot words read zero, and every compare register reads 0xFFFFFFFF.
- R2: With divider value D, the count advances by one on the 2×(D+1)-th rising edge after reset or after the last divider write, and then every 2×(D+1) edges. A divider write restarts that window.
- R3: A write to offset 0x00 loads the low counter word and a write to 0x04 loads the high word. In a cycle with either write, the tick increment is dropped.
- R4: When a tick moves the low word from 0xFFFFFFFF to zero, the high word increments on that same edge.
- R5: Writing a value with bit 0 set to offset 0x30 copies the full 64-bit count, as it stood before that edge, into the snapshot words at 0x34 (low) and 0x38 (high). A write with bit 0 clear changes nothing, and 0x30 reads zero.
- R6: Status bit n (offset 0x20) sets on the tick edge at which the low word becomes equal to compare register n. Compare register n sits at offset 0x08+4n. Loading the counter directly with that value sets nothing.
- R7: Writing 1 to status bit n clears it, and writing 0 leaves it. If a clear and a new event for the same bit fall on one edge, the bit stays set.
- R8: Interrupt output n is high exactly when status bit n and enable bit n (offset 0x24) are both set. With the enable clear, the status bit still records events.
- R9: When bit 0 of offset 0x28 is set, an event on channel 5 raises the watchdog reset output for exactly one cycle. That cycle is the one in which status bit 5 first reads set. With the bit clear, the output stays low.
- R10: The divider lives at offset 0x2C. A read returns zero when the select is low, for offsets 0x3C and above, and for addresses that are not word aligned. Writes to such addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read (with bus_sel) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, combinational from bus_addr |
| irq | output | NUM_CH | Per-channel interrupt, status AND enable |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
Two pairs of functions can land on the same clock edge. A software status clear can meet a fresh compare event on the same bit. A capture command can meet a tick that carries into the high word. The bench restarts the divider with a write so that it knows the phase exactly. It then issues back-to-back writes that fall on consecutive tick edges, which puts a clear and a capture command exactly on an event edge. A behavioural model updates on every edge and is compared with read data, interrupts and the watchdog pulse every cycle. Directed checks confirm that the status bit survives the collision and that the snapshot holds the pre-increment value.

// File: rtl/lmt_pkg.sv
package lmt_pkg;

   localparam int unsigned OFS_CNT_LO    = 32'h00;
   localparam int unsigned OFS_CNT_HI    = 32'h04;
   localparam int unsigned OFS_MATCH0    = 32'h08;
   localparam int unsigned OFS_STATUS    = 32'h20;
   localparam int unsigned OFS_IRQ_EN    = 32'h24;
   localparam int unsigned OFS_WDT_EN    = 32'h28;
   localparam int unsigned OFS_DIV       = 32'h2C;
   localparam int unsigned OFS_SNAP_CMD  = 32'h30;
   localparam int unsigned OFS_SNAP_LO   = 32'h34;
   localparam int unsigned OFS_SNAP_HI   = 32'h38;
   localparam int unsigned MAX_CH        = 6;

   typedef enum logic [3:0] {
      RS_NONE,
      RS_CNT_LO,
      RS_CNT_HI,
      RS_MATCH,
      RS_STATUS,
      RS_IRQ_EN,
      RS_WDT_EN,
      RS_DIV,
      RS_SNAP_CMD,
      RS_SNAP_LO,
      RS_SNAP_HI
   } reg_sel_e;

   typedef struct packed {
      reg_sel_e   sel;
      logic [2:0] ch;
   } reg_dec_t;

   function automatic reg_dec_t decode_addr(input logic [31:0] a, input int unsigned nch);
      reg_dec_t r;
      r.sel = RS_NONE;
      r.ch  = '0;
      if (a[1:0] == 2'b00) begin
         case (a)
            OFS_CNT_LO:   r.sel = RS_CNT_LO;
            OFS_CNT_HI:   r.sel = RS_CNT_HI;
            OFS_STATUS:   r.sel = RS_STATUS;
            OFS_IRQ_EN:   r.sel = RS_IRQ_EN;
            OFS_WDT_EN:   r.sel = RS_WDT_EN;
            OFS_DIV:      r.sel = RS_DIV;
            OFS_SNAP_CMD: r.sel = RS_SNAP_CMD;
            OFS_SNAP_LO:  r.sel = RS_SNAP_LO;
            OFS_SNAP_HI:  r.sel = RS_SNAP_HI;
            default: begin
               if (a >= OFS_MATCH0 && a < OFS_MATCH0 + 32'(4 * nch)) begin
                  r.sel = RS_MATCH;
                  r.ch  = 3'((a - OFS_MATCH0) >> 2);
               end
            end
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/lmt_prescaler.sv
module lmt_prescaler #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic             restart,
   output logic             tick
);
   localparam int unsigned PH_W = DIV_W + 1;

   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] limit;

   // period of 2*(div+1) input clocks: phase runs 0 .. 2*div+1
   assign limit = {div_val, 1'b1};
   assign tick  = (phase_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (restart || tick)
         phase_q <= '0;
      else
         phase_q <= phase_q + 1'b1;
   end
endmodule

// File: rtl/lmt_counter.sv
module lmt_counter #(
   parameter int unsigned WORD_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic [WORD_W-1:0]   wdata,
   input  logic                tick,
   input  logic                snap_req,
   output logic [2*WORD_W-1:0] count,
   output logic [2*WORD_W-1:0] snap,
   output logic [WORD_W-1:0]   next_lo,
   output logic                cnt_wr
);
   localparam int unsigned FULL_W = 2 * WORD_W;

   logic [WORD_W-1:0] lo_q, hi_q;
   logic [FULL_W-1:0] snap_q;
   logic              lo_wrap;

   assign cnt_wr  = wr_lo | wr_hi;
   assign next_lo = lo_q + 1'b1;
   assign lo_wrap = &lo_q;
   assign count   = {hi_q, lo_q};
   assign snap    = snap_q;

   // low word: a software load takes precedence and drops the tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lo_q <= '0;
      else if (wr_lo)
         lo_q <= wdata;
      else if (tick && !cnt_wr)
         lo_q <= next_lo;
   end

   // high word: carry lands on the same edge as the low-word wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_q <= '0;
      else if (wr_hi)
         hi_q <= wdata;
      else if (tick && !cnt_wr && lo_wrap)
         hi_q <= hi_q + 1'b1;
   end

   // snapshot captures the value present before this edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         snap_q <= '0;
      else if (snap_req)
         snap_q <= {hi_q, lo_q};
   end
endmodule

// File: rtl/lmt_match_bank.sv
module lmt_match_bank #(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned WORD_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        wr_match,
   input  logic [WORD_W-1:0]        wdata,
   input  logic                     tick,
   input  logic                     cnt_wr,
   input  logic [WORD_W-1:0]        next_lo,
   input  logic [NUM_CH-1:0]        clr_mask,
   output logic [NUM_CH*WORD_W-1:0] match_flat,
   output logic [NUM_CH-1:0]        hit,
   output logic [NUM_CH-1:0]        status
);
   logic [NUM_CH-1:0] status_q;
   logic              advance;

   assign advance = tick & ~cnt_wr;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [WORD_W-1:0] cmp_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cmp_q <= '1;
         else if (wr_match[c])
            cmp_q <= wdata;
      end

      // compare against the value the low word is about to take
      assign hit[c] = advance & (next_lo == cmp_q);
      assign match_flat[c*WORD_W +: WORD_W] = cmp_q;
   end

   // a new event outranks a software clear on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= '0;
      else
         status_q <= (status_q & ~clr_mask) | hit;
   end

   assign status = status_q;
endmodule

// File: rtl/latched_match_timer.sv
module latched_match_timer
   import lmt_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned NUM_CH  = 6,
   parameter int unsigned DIV_W   = 16,
   parameter bit          HAS_WDT = 1'b1,
   parameter int unsigned WDT_CH  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq,
   output logic              wdt_rst
);
   localparam int unsigned FULL_W = 2 * WORD_W;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("NUM_CH must lie in 1..%0d", MAX_CH);
   end
   if (ADDR_W < 6 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 6..32");
   end
   if (WORD_W > 32 || WORD_W < DIV_W || WORD_W < NUM_CH) begin : g_bad_word
      $error("WORD_W must hold the divider and status fields and be at most 32");
   end
   if (HAS_WDT && WDT_CH >= NUM_CH) begin : g_bad_wdt
      $error("WDT_CH must name an existing channel");
   end

   logic [31:0]          addr_ext;
   reg_dec_t             dec;
   logic                 wen;
   logic                 tick;
   logic                 cnt_wr;
   logic                 snap_req;
   logic [FULL_W-1:0]    count;
   logic [FULL_W-1:0]    snap;
   logic [WORD_W-1:0]    next_lo;
   logic [NUM_CH-1:0]    wr_match;
   logic [NUM_CH-1:0]    clr_mask;
   logic [NUM_CH-1:0]    hit;
   logic [NUM_CH-1:0]    status;
   logic [NUM_CH*WORD_W-1:0] match_flat;
   logic [NUM_CH-1:0]    en_q;
   logic [DIV_W-1:0]     div_q;
   logic                 div_wr;
   logic                 wdt_en_q;
   logic                 wdt_q;
   logic [WORD_W-1:0]    rd;

   assign addr_ext = 32'(bus_addr);
   assign dec      = decode_addr(addr_ext, NUM_CH);
   assign wen      = bus_sel & bus_wr;
   assign div_wr   = wen && dec.sel == RS_DIV;
   assign snap_req = wen && dec.sel == RS_SNAP_CMD && bus_wdata[0];
   assign clr_mask = (wen && dec.sel == RS_STATUS) ? bus_wdata[NUM_CH-1:0] : '0;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_wsel
      assign wr_match[c] = wen && dec.sel == RS_MATCH && dec.ch == 3'(c);
   end

   lmt_prescaler #(.DIV_W(DIV_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_val (div_q),
      .restart (div_wr),
      .tick    (tick)
   );

   lmt_counter #(.WORD_W(WORD_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (wen && dec.sel == RS_CNT_LO),
      .wr_hi    (wen && dec.sel == RS_CNT_HI),
      .wdata    (bus_wdata),
      .tick     (tick),
      .snap_req (snap_req),
      .count    (count),
      .snap     (snap),
      .next_lo  (next_lo),
      .cnt_wr   (cnt_wr)
   );

   lmt_match_bank #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_match   (wr_match),
      .wdata      (bus_wdata),
      .tick       (tick),
      .cnt_wr     (cnt_wr),
      .next_lo    (next_lo),
      .clr_mask   (clr_mask),
      .match_flat (match_flat),
      .hit        (hit),
      .status     (status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         div_q <= '0;
      end else begin
         if (wen && dec.sel == RS_IRQ_EN) en_q <= bus_wdata[NUM_CH-1:0];
         if (div_wr)                      div_q <= bus_wdata[DIV_W-1:0];
      end
   end

   if (HAS_WDT) begin : g_wdt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wdt_en_q <= 1'b0;
            wdt_q    <= 1'b0;
         end else begin
            if (wen && dec.sel == RS_WDT_EN) wdt_en_q <= bus_wdata[0];
            wdt_q <= wdt_en_q & hit[WDT_CH];
         end
      end
   end else begin : g_no_wdt
      assign wdt_en_q = 1'b0;
      assign wdt_q    = 1'b0;
   end

   always_comb begin
      rd = '0;
      if (bus_sel) begin
         case (dec.sel)
            RS_CNT_LO:  rd = count[WORD_W-1:0];
            RS_CNT_HI:  rd = count[FULL_W-1:WORD_W];
            RS_MATCH:   rd = match_flat[32'(dec.ch)*WORD_W +: WORD_W];
            RS_STATUS:  rd = WORD_W'(status);
            RS_IRQ_EN:  rd = WORD_W'(en_q);
            RS_WDT_EN:  rd = WORD_W'(wdt_en_q);
            RS_DIV:     rd = WORD_W'(div_q);
            RS_SNAP_LO: rd = snap[WORD_W-1:0];
            RS_SNAP_HI: rd = snap[FULL_W-1:WORD_W];
            default:    rd = '0;
         endcase
      end
   end

   assign bus_rdata = rd;
   assign irq       = status & en_q;
   assign wdt_rst   = wdt_q;
endmodule

// File: rtl/lmt_checker.sv
module lmt_checker #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned NUM_CH  = 6,
   parameter bit          HAS_WDT = 1'b1,
   parameter int unsigned WDT_CH  = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick,
   input logic                cnt_wr,
   input logic [2*WORD_W-1:0] count,
   input logic                snap_req,
   input logic [2*WORD_W-1:0] snap,
   input logic [NUM_CH-1:0]   hit,
   input logic [NUM_CH-1:0]   clr_mask,
   input logic [NUM_CH-1:0]   status,
   input logic                wdt_rst
);
   localparam int unsigned FULL_W = 2 * WORD_W;

   // R2: the count moves only on a prescaler tick or a software load
   assert_count_moves_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> $past(tick || cnt_wr));

   // R4: low-word wrap carries into the high word on the same edge
   assert_carry_same_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tick && !cnt_wr && (&count[WORD_W-1:0])) |->
         (count[WORD_W-1:0] == '0 &&
          count[FULL_W-1:WORD_W] == $past(count[FULL_W-1:WORD_W]) + 1'b1));

   // R5: a capture holds the pre-edge count
   assert_snapshot_pre_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(snap_req) |-> (snap == $past(count)));

   // R6: an event is recorded in status on the following cycle
   assert_event_recorded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((status & $past(hit)) == $past(hit)));

   // R7: a clear without a colliding event leaves the bit low
   assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status & $past(clr_mask & ~hit)) == '0);

   if (HAS_WDT) begin : g_wdt_chk
      // R9: the pulse lasts one cycle
      assert_wdt_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
         wdt_rst |=> !wdt_rst);
      // R9: the pulse coincides with the watchdog status bit
      assert_wdt_with_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
         wdt_rst |-> status[WDT_CH]);
   end
endmodule

bind latched_match_timer lmt_checker #(
   .WORD_W  (WORD_W),
   .NUM_CH  (NUM_CH),
   .HAS_WDT (HAS_WDT),
   .WDT_CH  (WDT_CH)
) u_lmt_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .cnt_wr   (cnt_wr),
   .count    (count),
   .snap_req (snap_req),
   .snap     (snap),
   .hit      (hit),
   .clr_mask (clr_mask),
   .status   (status),
   .wdt_rst  (wdt_rst)
);

// File: tb/latched_match_timer_bench.sv
module latched_match_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 6;
   localparam int LIMIT      = 100000;

   logic        clk       = 1'b0;
   logic        rst_n     = 1'b0;
   logic        bus_sel   = 1'b0;
   logic        bus_wr    = 1'b0;
   logic [7:0]  bus_addr  = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] irq;
   logic        wdt_rst;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   latched_match_timer u_latched_match_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq),
      .wdt_rst   (wdt_rst)
   );

   // ---------------- behavioural reference ----------------
   logic [63:0]    m_cnt    = '0;
   logic [63:0]    m_snap   = '0;
   logic [31:0]    m_match [NCH];
   logic [NCH-1:0] m_status = '0;
   logic [NCH-1:0] m_en     = '0;
   bit             m_wdt_en = 1'b0;
   bit             m_wdt    = 1'b0;
   int             m_phase  = 0;
   int             m_div    = 0;

   initial for (int i = 0; i < NCH; i++) m_match[i] = 32'hFFFF_FFFF;

   task automatic model_step();
      bit             w, tk, cw;
      logic [NCH-1:0] hits;
      logic [31:0]    nxt;
      if (!rst_n) begin
         m_cnt = '0; m_snap = '0; m_status = '0; m_en = '0;
         m_wdt_en = 1'b0; m_wdt = 1'b0; m_phase = 0; m_div = 0;
         for (int i = 0; i < NCH; i++) m_match[i] = 32'hFFFF_FFFF;
         return;
      end
      w    = bus_sel && bus_wr;
      tk   = (m_phase == 2 * m_div + 1);
      cw   = w && (bus_addr == 8'h00 || bus_addr == 8'h04);
      nxt  = m_cnt[31:0] + 32'd1;
      hits = '0;
      if (tk && !cw)
         for (int i = 0; i < NCH; i++) if (nxt == m_match[i]) hits[i] = 1'b1;
      m_wdt = m_wdt_en && hits[5];
      if (w && bus_addr == 8'h30 && bus_wdata[0]) m_snap = m_cnt;
      if (w && bus_addr == 8'h20) m_status = m_status & ~bus_wdata[NCH-1:0];
      m_status = m_status | hits;
      if (cw) begin
         if (bus_addr == 8'h00) m_cnt[31:0]  = bus_wdata;
         else                   m_cnt[63:32] = bus_wdata;
      end else if (tk) begin
         m_cnt = m_cnt + 64'd1;
      end
      m_phase = ((w && bus_addr == 8'h2C) || tk) ? 0 : m_phase + 1;
      if (w) begin
         case (bus_addr)
            8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C:
               m_match[(int'(bus_addr) - 8) / 4] = bus_wdata;
            8'h24: m_en     = bus_wdata[NCH-1:0];
            8'h28: m_wdt_en = bus_wdata[0];
            8'h2C: m_div    = int'(bus_wdata[15:0]);
            default: ;
         endcase
      end
   endtask

   function automatic logic [31:0] exp_rdata();
      if (!bus_sel) return '0;
      case (bus_addr)
         8'h00: return m_cnt[31:0];
         8'h04: return m_cnt[63:32];
         8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C:
                return m_match[(int'(bus_addr) - 8) / 4];
         8'h20: return 32'(m_status);
         8'h24: return 32'(m_en);
         8'h28: return 32'(m_wdt_en);
         8'h2C: return 32'(m_div);
         8'h34: return m_snap[31:0];
         8'h38: return m_snap[63:32];
         default: return '0;
      endcase
   endfunction

   function automatic string req_of(logic [7:0] a);
      case (a)
         8'h00, 8'h04: return "R3";
         8'h20:        return "R6";
         8'h34, 8'h38: return "R5";
         8'h2C:        return "R2";
         default:      return "R10";
      endcase
   endfunction

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // every cycle: update the model at the edge, compare shortly after
   always begin
      @(posedge clk);
      model_step();
      #(CLK_PERIOD/5);
      if (!done) begin
         check(req_of(bus_addr), "model read data", 64'(bus_rdata), 64'(exp_rdata()));
         check("R8", "model irq", 64'(irq), 64'(m_status & m_en));
         check("R9", "model watchdog pulse", 64'(wdt_rst), 64'(m_wdt));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_rd(string req, string what, logic [7:0] a, logic [31:0] e);
      logic [31:0] d;
      peek(a, d);
      check(req, what, 64'(d), 64'(e));
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      #(CLK_PERIOD * LIMIT);
      if (!done) begin
         done = 1'b1;
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v0;
      // R1: reset values read while reset is held
      step(2);
      expect_rd("R1", "compare 0 reset", 8'h08, 32'hFFFF_FFFF);
      expect_rd("R1", "compare 5 reset", 8'h1C, 32'hFFFF_FFFF);
      expect_rd("R1", "status reset",    8'h20, 32'h0);
      expect_rd("R1", "count lo reset",  8'h00, 32'h0);
      expect_rd("R1", "snapshot hi reset", 8'h38, 32'h0);
      expect_rd("R1", "divider reset",   8'h2C, 32'h0);
      expect_rd("R1", "enable reset",    8'h24, 32'h0);
      check("R1", "irq reset", 64'(irq), 64'h0);
      step(1);
      rst_n = 1'b1;

      // R2: divider 3 gives one step per 8 edges after the divider write
      wr(8'h2C, 32'd3);
      peek(8'h00, v0);
      step(7);
      expect_rd("R2", "count before 8th edge", 8'h00, v0);
      step(1);
      expect_rd("R2", "count at 8th edge", 8'h00, v0 + 32'd1);
      step(8);
      expect_rd("R2", "count at 16th edge", 8'h00, v0 + 32'd2);

      // R3, R4: load on a tick edge drops the tick; wrap carries
      wr(8'h2C, 32'd1);
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h04, 32'd7);
      expect_rd("R3", "low kept on load edge", 8'h00, 32'hFFFF_FFFF);
      expect_rd("R3", "high loaded", 8'h04, 32'd7);
      step(3);
      expect_rd("R3", "low before wrap", 8'h00, 32'hFFFF_FFFF);
      step(1);
      expect_rd("R4", "low after wrap", 8'h00, 32'h0);
      expect_rd("R4", "high after wrap", 8'h04, 32'd8);

      // R5: capture command
      wr(8'h2C, 32'd1000);
      wr(8'h00, 32'h1234);
      wr(8'h04, 32'hABCD);
      wr(8'h30, 32'd1);
      expect_rd("R5", "snapshot lo", 8'h34, 32'h1234);
      expect_rd("R5", "snapshot hi", 8'h38, 32'hABCD);
      wr(8'h00, 32'h5555);
      wr(8'h30, 32'hFFFF_FFFE);
      expect_rd("R5", "bit0 clear keeps snapshot", 8'h34, 32'h1234);
      expect_rd("R5", "command reads zero", 8'h30, 32'h0);
      wr(8'h30, 32'd1);
      expect_rd("R5", "recapture", 8'h34, 32'h5555);
      // R5: capture on the wrap edge holds the pre-increment count
      wr(8'h04, 32'd2);
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h2C, 32'd0);
      wr(8'h30, 32'd1);
      expect_rd("R5", "capture on wrap lo", 8'h34, 32'hFFFF_FFFF);
      expect_rd("R5", "capture on wrap hi", 8'h38, 32'd2);

      // R6, R8: event on channel 2
      wr(8'h2C, 32'd1000);
      wr(8'h20, 32'h3F);
      wr(8'h24, 32'h3F);
      wr(8'h00, 32'd100);
      wr(8'h10, 32'd103);
      wr(8'h2C, 32'd0);
      step(5);
      expect_rd("R6", "no event before match", 8'h20, 32'h0);
      step(1);
      expect_rd("R6", "event at match edge", 8'h20, 32'h4);
      check("R8", "irq with enable", 64'(irq), 64'h4);
      wr(8'h2C, 32'd1000);
      wr(8'h24, 32'h3B);
      check("R8", "irq gated off", 64'(irq), 64'h0);
      expect_rd("R8", "status kept while gated", 8'h20, 32'h4);
      wr(8'h24, 32'h3F);
      check("R8", "irq regated on", 64'(irq), 64'h4);
      wr(8'h20, 32'h3B);
      expect_rd("R7", "zero bit leaves status", 8'h20, 32'h4);
      wr(8'h20, 32'h4);
      expect_rd("R7", "one bit clears status", 8'h20, 32'h0);
      wr(8'h08, 32'd500);
      wr(8'h00, 32'd500);
      step(3);
      expect_rd("R6", "direct load makes no event", 8'h20, 32'h0);

      // R7: clear and event on the same edge
      wr(8'h00, 32'd200);
      wr(8'h14, 32'd203);
      wr(8'h2C, 32'd0);
      wr(8'h20, 32'h8);
      wr(8'h20, 32'h8);
      wr(8'h20, 32'h8);
      expect_rd("R7", "event outranks clear", 8'h20, 32'h8);
      wr(8'h20, 32'h8);
      expect_rd("R7", "later clear takes", 8'h20, 32'h0);

      // R9: watchdog pulse
      wr(8'h2C, 32'd1000);
      wr(8'h20, 32'h3F);
      wr(8'h28, 32'd1);
      wr(8'h00, 32'd300);
      wr(8'h1C, 32'd302);
      wr(8'h2C, 32'd0);
      step(3);
      check("R9", "no pulse before event", 64'(wdt_rst), 64'h0);
      step(1);
      check("R9", "pulse on event", 64'(wdt_rst), 64'h1);
      expect_rd("R9", "status with pulse", 8'h20, 32'h20);
      step(1);
      check("R9", "pulse one cycle", 64'(wdt_rst), 64'h0);
      wr(8'h2C, 32'd1000);
      wr(8'h20, 32'h3F);
      wr(8'h28, 32'd0);
      wr(8'h00, 32'd400);
      wr(8'h1C, 32'd402);
      wr(8'h2C, 32'd0);
      for (int i = 0; i < 8; i++) begin
         step(1);
         check("R9", "no pulse when disabled", 64'(wdt_rst), 64'h0);
      end
      expect_rd("R9", "event still recorded", 8'h20, 32'h20);

      // R10: unmapped and misaligned accesses
      wr(8'h2C, 32'd1000);
      wr(8'h3C, 32'hFFFF_FFFF);
      wr(8'h22, 32'hFFFF_FFFF);
      expect_rd("R10", "misaligned write ignored", 8'h20, 32'h20);
      expect_rd("R10", "offset 0x3C reads zero", 8'h3C, 32'h0);
      expect_rd("R10", "offset 0x40 reads zero", 8'h40, 32'h0);
      expect_rd("R10", "misaligned read zero", 8'h22, 32'h0);
      expect_rd("R10", "compare 5 intact", 8'h1C, 32'd402);
      expect_rd("R10", "compare 0 intact", 8'h08, 32'd500);
      expect_rd("R10", "divider intact", 8'h2C, 32'd1000);
      bus_sel = 1'b0; bus_addr = 8'h08;
      #1;
      check("R10", "no select reads zero", 64'(bus_rdata), 64'h0);
      step(4);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule